// File: doc/BRIEF.md
# Byte-Wise Programming Sequencer for a Latched EPROM

This block takes an external EPROM with internal address latches through in-system programming, one byte at a time. A host pulses `start`. The block then sets the internal-boot select, so that the surrounding controller keeps running from its own memory, and after a settling gap it raises the programming-voltage enable. Raising that enable also takes the EPROM's latch strobe away from the normal bus ALE and gives it to the block's manual latch line.

Each byte arrives as a three-byte record on a valid/ready byte stream, in this order: address high, address low, data. For each record the block does the following in turn:

1. It puts the address on the high-address bus and the multiplexed low bus while the latch line is high, then drops the latch line to capture the address.
2. It drives the data onto the low bus and holds the program strobe low for a fixed number of cycles.
3. It releases the bus and reads the location back with output enable low, then compares the byte it reads with the byte it wrote.

If the bytes match, the block takes the next record. If they differ, it raises a sticky error flag, drops the programming controls and stops with the failing address on a port.

After the record marked last has been verified, the programming voltage is removed and the internal-boot select is cleared. Execution can then move to the freshly programmed EPROM. All gaps and the pulse width are counted in clock cycles set by parameters.

Top module: `eprom_prog_seq`

## Requirements
- R1: After reset: `int_boot`=0, `vpp_en`=0, `latch_ctl`=1, `pgm_n`=1, `oe_n`=1, `ad_oe`=0, `s_ready`=0, `busy`=0, `done`=0, `err`=0.
- R2: `start` is accepted when the block is idle or failed. In the first cycle after it is accepted, `int_boot` is 1 and `vpp_en` is 0. `vpp_en` rises GAP_CYC cycles later, and `int_boot` stays 1 through the whole session.
- R3: `ale_out` equals `bus_ale` whenever `vpp_en` is 0, and equals `latch_ctl` whenever `vpp_en` is 1.
- R4: Records are taken as three stream bytes in the order address high, address low, data, with `s_last` sampled on the data byte. Each byte is taken on a cycle with `s_valid` and `s_ready` both high. `s_ready` is high only while a record is being received, and during that time `latch_ctl` and `pgm_n` are both 1. No byte is taken while the block is idle or failed.
- R5: Address phase. `ad_oe`=1, `addr_hi` carries the high address byte and `ad_out` the low address byte. `latch_ctl` is 1 for GAP_CYC cycles, then 0 for GAP_CYC cycles with the address still driven. `latch_ctl` then stays 0 until the read-back ends.
- R6: Data phase. `ad_out` carries the data byte for GAP_CYC cycles. `pgm_n` is then 0 for exactly PULSE_CYC cycles, and the data is held for GAP_CYC more cycles with `pgm_n`=1.
- R7: Read-back. `ad_oe`=0 and `oe_n`=0 for GAP_CYC cycles with `addr_hi` held. `ad_in` is sampled in the last of these cycles. If it equals the data byte, the next record is received, or the session finishes after the last record.
- R8: On a read-back mismatch: `err`=1, `err_addr`={high, low} of the failing record, `vpp_en`=0, `pgm_n`=1, `latch_ctl`=1, `busy`=0, `s_ready`=0 and `int_boot`=1. These values hold until the next `start`.
- R9: After the last record verifies: `vpp_en`=0 with `int_boot`=1 for GAP_CYC cycles. Then `int_boot`=0, `busy`=0 and `done`=1.
- R10: An accepted `start` clears `done` and `err`. A `start` pulse while `busy` is 1 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming session |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Stream byte accepted this cycle when valid |
| s_data | input | BW | Stream byte |
| s_last | input | 1 | Marks the data byte of the final record |
| bus_ale | input | 1 | Normal bus address-latch strobe |
| ale_out | output | 1 | Latch strobe to the EPROM |
| int_boot | output | 1 | Run from internal memory select |
| vpp_en | output | 1 | Programming-voltage enable |
| latch_ctl | output | 1 | Manual latch line (1 = transparent) |
| pgm_n | output | 1 | Program strobe, active low |
| oe_n | output | 1 | EPROM output enable, active low |
| addr_hi | output | BW | High address bus |
| ad_out | output | BW | Multiplexed low bus, driven value |
| ad_oe | output | 1 | Drive enable for the low bus |
| ad_in | input | BW | Multiplexed low bus, read value |
| busy | output | 1 | Session in progress |
| done | output | 1 | Last session finished with every byte verified |
| err | output | 1 | Last session stopped on a verify mismatch |
| err_addr | output | 2*BW | Address of the failing byte |

## Verification
The bench runs a reference trace of every control line against the design on every cycle. It does this while a small EPROM model with erased-is-ones, program-clears-bits behaviour answers the read-backs.

The corner cases it targets are these:
- A byte that cannot be programmed because bits were already cleared. A design that sampled the read-back too early, or ignored the compare, would report success and move on. One that stopped in the wrong place would show the wrong `err_addr` or would swallow the next record's bytes.
- Programming the erased value 0xFF at the top address.
- A stray `start` in the middle of a session. A design that honoured it would restart the power-up order.
- A restart after a failure, which must clear the error flag.

Throughout the run, `bus_ale` toggles freely. A design that handed the latch strobe over at the wrong moment would show up on `ale_out` in the gap before the voltage enable rises or during the final wind-down.

// File: rtl/eprom_prog_seq.sv
module eprom_prog_seq #(
  parameter int GAP_CYC   = 2,
  parameter int PULSE_CYC = 5,
  parameter int BW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [BW-1:0] s_data,
  input  logic          s_last,
  input  logic          bus_ale,
  output logic          ale_out,
  output logic          int_boot,
  output logic          vpp_en,
  output logic          latch_ctl,
  output logic          pgm_n,
  output logic          oe_n,
  output logic [BW-1:0] addr_hi,
  output logic [BW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [BW-1:0] ad_in,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [2*BW-1:0] err_addr
);
  localparam int MAXC = (GAP_CYC > PULSE_CYC) ? GAP_CYC : PULSE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] GAP_LD   = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] PULSE_LD = CW'(PULSE_CYC - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_BOOT, S_VPP, S_GAH, S_GAL, S_GD, S_ADR, S_LAT,
    S_DAT, S_PUL, S_REC, S_RD, S_FIN, S_FAIL
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt;
  logic [BW-1:0] ah, al, dat;
  logic last_r, done_r, err_r;

  wire go   = start && (st == S_IDLE || st == S_FAIL);
  wire tz   = (cnt == '0);
  wire take = s_valid && s_ready;
  wire bad  = (st == S_RD) && tz && (ad_in != dat);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE, S_FAIL: if (start) nxt = S_BOOT;
      S_BOOT: if (tz) nxt = S_VPP;
      S_VPP:  if (tz) nxt = S_GAH;
      S_GAH:  if (s_valid) nxt = S_GAL;
      S_GAL:  if (s_valid) nxt = S_GD;
      S_GD:   if (s_valid) nxt = S_ADR;
      S_ADR:  if (tz) nxt = S_LAT;
      S_LAT:  if (tz) nxt = S_DAT;
      S_DAT:  if (tz) nxt = S_PUL;
      S_PUL:  if (tz) nxt = S_REC;
      S_REC:  if (tz) nxt = S_RD;
      S_RD:   if (tz) nxt = bad ? S_FAIL : (last_r ? S_FIN : S_GAH);
      S_FIN:  if (tz) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ah     <= '0;
      al     <= '0;
      dat    <= '0;
      last_r <= 1'b0;
      done_r <= 1'b0;
      err_r  <= 1'b0;
    end else begin
      st <= nxt;
      if (nxt != st)    cnt <= (nxt == S_PUL) ? PULSE_LD : GAP_LD;
      else if (!tz)     cnt <= cnt - 1'b1;
      if (take && st == S_GAH) ah <= s_data;
      if (take && st == S_GAL) al <= s_data;
      if (take && st == S_GD) begin
        dat    <= s_data;
        last_r <= s_last;
      end
      if (go)                                done_r <= 1'b0;
      else if (st == S_FIN && tz)            done_r <= 1'b1;
      if (go)                                err_r  <= 1'b0;
      else if (bad)                          err_r  <= 1'b1;
    end
  end

  wire drv_adr  = (st == S_ADR) || (st == S_LAT);
  wire drv_dat  = (st inside {S_DAT, S_PUL, S_REC});
  wire hold_hi  = drv_adr || drv_dat || (st == S_RD);

  assign s_ready   = (st inside {S_GAH, S_GAL, S_GD});
  assign int_boot  = (st != S_IDLE);
  assign vpp_en    = (st inside {S_VPP, S_GAH, S_GAL, S_GD, S_ADR, S_LAT,
                                 S_DAT, S_PUL, S_REC, S_RD});
  assign latch_ctl = !(st inside {S_LAT, S_DAT, S_PUL, S_REC, S_RD});
  assign pgm_n     = (st != S_PUL);
  assign oe_n      = (st != S_RD);
  assign ad_oe     = drv_adr || drv_dat;
  assign addr_hi   = hold_hi ? ah : '0;
  assign ad_out    = drv_adr ? al : (drv_dat ? dat : '0);
  assign ale_out   = vpp_en ? latch_ctl : bus_ale;
  assign busy      = !(st == S_IDLE || st == S_FAIL);
  assign done      = done_r;
  assign err       = err_r;
  assign err_addr  = {ah, al};
endmodule

// File: rtl/eprom_prog_seq_chk.sv
module eprom_prog_seq_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_ready,
  input logic          int_boot,
  input logic          vpp_en,
  input logic          latch_ctl,
  input logic          pgm_n,
  input logic          oe_n,
  input logic          ad_oe,
  input logic [BW-1:0] ad_out,
  input logic          busy,
  input logic          done,
  input logic          err
);
  // R2
  boot_before_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vpp_en) |-> int_boot && $past(int_boot));

  // R4
  rx_lines_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> vpp_en && latch_ctl && pgm_n);

  // R5
  latch_with_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(latch_ctl) |-> ad_oe && vpp_en);

  // R6
  pulse_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |-> vpp_en && !latch_ctl && ad_oe && oe_n);

  // R6
  pulse_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pgm_n && !$past(pgm_n)) |-> $stable(ad_out));

  // R7
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !ad_oe && pgm_n);

  // R8
  fail_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy && !vpp_en && pgm_n && int_boot);

  // R9
  handback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_boot) |-> !vpp_en && done && !busy);
endmodule

bind eprom_prog_seq eprom_prog_seq_chk #(.BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .int_boot(int_boot),
  .vpp_en(vpp_en), .latch_ctl(latch_ctl), .pgm_n(pgm_n), .oe_n(oe_n),
  .ad_oe(ad_oe), .ad_out(ad_out), .busy(busy), .done(done), .err(err)
);

// File: tb/eprom_prog_seq_bench.sv
module eprom_prog_seq_bench;
  localparam int G = 2;
  localparam int P = 5;

  logic clk = 0, rst_n = 0, start = 0, s_valid = 0, s_last = 0, bus_ale = 0;
  logic [7:0] s_data = 0;
  logic s_ready, ale_out, int_boot, vpp_en, latch_ctl, pgm_n, oe_n, ad_oe;
  logic busy, done, err;
  logic [7:0] addr_hi, ad_out, ad_in;
  logic [15:0] err_addr;

  eprom_prog_seq #(.GAP_CYC(G), .PULSE_CYC(P), .BW(8)) u_eprom_prog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .bus_ale(bus_ale), .ale_out(ale_out),
    .int_boot(int_boot), .vpp_en(vpp_en), .latch_ctl(latch_ctl), .pgm_n(pgm_n),
    .oe_n(oe_n), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
    .busy(busy), .done(done), .err(err), .err_addr(err_addr));

  always #4 clk = ~clk;

  typedef struct packed {
    logic ib, vpp, lat, pgm, oe, adoe, rdy, bsy, dn, er;
    logic [7:0] ahi, ad;
    logic [15:0] ea;
  } exp_t;

  exp_t q[$];
  logic [8:0] strm[$];
  logic [23:0] recs[$];
  logic [7:0] chip_mem[int];
  logic [7:0] pred_mem[int];
  int vectors = 0, miss = 0, cyc = 0;
  logic cur_done = 0, cur_err = 0;
  logic [15:0] cur_ea = 0;

  // EPROM model: erased bytes read 0xFF, programming can only clear bits
  logic [15:0] lat_a = 0;
  logic [7:0] rd_r = 0;
  always @(posedge clk) begin
    if (vpp_en && !pgm_n)
      chip_mem[int'(lat_a)] = (chip_mem.exists(int'(lat_a)) ? chip_mem[int'(lat_a)] : 8'hFF) & ad_out;
    rd_r <= chip_mem.exists(int'(lat_a)) ? chip_mem[int'(lat_a)] : 8'hFF;
    if (ale_out) lat_a <= {addr_hi, ad_out};
  end
  assign ad_in = oe_n ? 8'h00 : rd_r;

  always @(posedge clk) begin
    #2;
    cyc++;
    bus_ale = (cyc % 3 == 0);
  end

  // stream driver
  always @(posedge clk) begin
    logic tk;
    tk = s_valid && s_ready;
    #2;
    if (tk && strm.size() > 0) void'(strm.pop_front());
    if (strm.size() > 0) begin
      s_valid = 1;
      {s_last, s_data} = strm[0];
    end else begin
      s_valid = 0;
      s_last = 0;
      s_data = 0;
    end
  end

  function automatic exp_t mk(input logic ib, vpp, lat, pgm, oe, adoe, rdy, bsy, dn, er,
                              input logic [7:0] ahi, ad, input logic [15:0] ea);
    exp_t e;
    e = '{ib, vpp, lat, pgm, oe, adoe, rdy, bsy, dn, er, ahi, ad, ea};
    return e;
  endfunction

  function automatic exp_t rest();
    if (cur_err) return mk(1,0,1,1,1,0,0,0,0,1,0,0,cur_ea);
    return mk(0,0,1,1,1,0,0,0,cur_done,0,0,0,0);
  endfunction

  task automatic put(input int n, input exp_t e);
    for (int i = 0; i < n; i++) q.push_back(e);
  endtask

  always @(negedge clk) begin
    exp_t e;
    if (q.size() > 0) begin
      e = q.pop_front();
      vectors++;
      if (int_boot !== e.ib) begin miss++; $display("FAIL R2 int_boot act=%b exp=%b @%0t", int_boot, e.ib, $time); end
      if (vpp_en !== e.vpp) begin miss++; $display("FAIL R2 vpp_en act=%b exp=%b @%0t", vpp_en, e.vpp, $time); end
      if (latch_ctl !== e.lat) begin miss++; $display("FAIL R5 latch_ctl act=%b exp=%b @%0t", latch_ctl, e.lat, $time); end
      if (pgm_n !== e.pgm) begin miss++; $display("FAIL R6 pgm_n act=%b exp=%b @%0t", pgm_n, e.pgm, $time); end
      if (oe_n !== e.oe) begin miss++; $display("FAIL R7 oe_n act=%b exp=%b @%0t", oe_n, e.oe, $time); end
      if (ad_oe !== e.adoe) begin miss++; $display("FAIL R5 ad_oe act=%b exp=%b @%0t", ad_oe, e.adoe, $time); end
      if (s_ready !== e.rdy) begin miss++; $display("FAIL R4 s_ready act=%b exp=%b @%0t", s_ready, e.rdy, $time); end
      if (busy !== e.bsy) begin miss++; $display("FAIL R9 busy act=%b exp=%b @%0t", busy, e.bsy, $time); end
      if (done !== e.dn) begin miss++; $display("FAIL R9/R10 done act=%b exp=%b @%0t", done, e.dn, $time); end
      if (err !== e.er) begin miss++; $display("FAIL R8/R10 err act=%b exp=%b @%0t", err, e.er, $time); end
      if (ale_out !== (e.vpp ? e.lat : bus_ale)) begin
        miss++; $display("FAIL R3 ale_out act=%b exp=%b @%0t", ale_out, (e.vpp ? e.lat : bus_ale), $time);
      end
      if ((e.adoe || !e.oe) && addr_hi !== e.ahi) begin
        miss++; $display("FAIL R5 addr_hi act=%h exp=%h @%0t", addr_hi, e.ahi, $time);
      end
      if (e.adoe && ad_out !== e.ad) begin
        miss++; $display("FAIL R6 ad_out act=%h exp=%h @%0t", ad_out, e.ad, $time);
      end
      if (e.er && err_addr !== e.ea) begin
        miss++; $display("FAIL R8 err_addr act=%h exp=%h @%0t", err_addr, e.ea, $time);
      end
    end
  end

  task automatic drain();
    do begin @(posedge clk); #2; end while (q.size() != 0);
  endtask

  // runs the records in recs; poke != 0 pulses start that many cycles into the session
  task automatic session(input int poke);
    logic [7:0] ah, al, d, got;
    int n;
    bit failed;
    drain();
    strm.delete();
    n = recs.size();
    for (int i = 0; i < n; i++) begin
      {ah, al, d} = recs[i];
      strm.push_back({1'b0, ah});
      strm.push_back({1'b0, al});
      strm.push_back({(i == n - 1), d});
    end
    q.push_back(rest());
    cur_done = 0; cur_err = 0;
    put(G, mk(1,0,1,1,1,0,0,1,0,0,0,0,0));
    put(G, mk(1,1,1,1,1,0,0,1,0,0,0,0,0));
    failed = 0;
    for (int i = 0; i < n && !failed; i++) begin
      {ah, al, d} = recs[i];
      // R4 receive, R5 address, R6 data/pulse, R7 read-back
      put(3, mk(1,1,1,1,1,0,1,1,0,0,0,0,0));
      put(G, mk(1,1,1,1,1,1,0,1,0,0,ah,al,0));
      put(G, mk(1,1,0,1,1,1,0,1,0,0,ah,al,0));
      put(G, mk(1,1,0,1,1,1,0,1,0,0,ah,d,0));
      put(P, mk(1,1,0,0,1,1,0,1,0,0,ah,d,0));
      put(G, mk(1,1,0,1,1,1,0,1,0,0,ah,d,0));
      put(G, mk(1,1,0,1,0,0,0,1,0,0,ah,0,0));
      got = (pred_mem.exists(int'({ah, al})) ? pred_mem[int'({ah, al})] : 8'hFF) & d;
      pred_mem[int'({ah, al})] = got;
      if (got != d) begin
        failed = 1;
        cur_err = 1;
        cur_ea = {ah, al};
      end
    end
    if (!failed) begin
      put(G, mk(1,0,1,1,1,0,0,1,0,0,0,0,0));
      cur_done = 1;
    end
    put(4, rest());
    start = 1;
    @(posedge clk); #2;
    start = 0;
    if (poke > 0) begin
      repeat (poke) @(posedge clk);
      #2; start = 1;   // R10: ignored while busy
      @(posedge clk); #2;
      start = 0;
    end
    drain();
  endtask

  initial begin
    #(8 * 100000);
    miss++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(negedge clk);
    vectors++;
    if ({int_boot, vpp_en, latch_ctl, pgm_n, oe_n, ad_oe, s_ready, busy, done, err} !== 10'b0011100000) begin
      miss++;
      $display("FAIL R1 reset outputs act=%b exp=%b",
               {int_boot, vpp_en, latch_ctl, pgm_n, oe_n, ad_oe, s_ready, busy, done, err}, 10'b0011100000);
    end
    @(posedge clk); #2;
    put(6, rest());
    drain();

    recs.delete();
    recs.push_back({8'h12, 8'h34, 8'hA5});
    recs.push_back({8'h12, 8'h35, 8'h00});
    recs.push_back({8'hFF, 8'hFF, 8'hFF});
    session(0);

    recs.delete();
    recs.push_back({8'h00, 8'h00, 8'h5A});
    session(3 * G + 5);

    recs.delete();
    recs.push_back({8'h12, 8'h36, 8'h0F});
    recs.push_back({8'h12, 8'h36, 8'hF0});
    recs.push_back({8'h20, 8'h00, 8'h11});
    session(0);
    put(8, rest());
    drain();

    recs.delete();
    recs.push_back({8'h40, 8'h01, 8'h3C});
    recs.push_back({8'h12, 8'h34, 8'hA5});
    session(0);
    put(6, rest());
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule